// File: doc/BRIEF.md
# Guarded Power-Down Entry Controller

This block decides when the chip stops its oscillator and enters a clock-stopped power-down state. Software reaches it through a one-byte power-control register on the register bus. Two bits of that register form a guarded key. The "arm" bit (bit 1) must be written first. The "go" bit (bit 6) must then be written in the very next instruction. Power-down is entered only after this pair of writes. A single write that sets both bits is rejected. Neither key bit is ever stored, so reads of either bit return zero.

An instruction-boundary strobe tells the block where each instruction ends. Any instruction that ends without a valid go write drops the armed condition. This includes an instruction that writes some other address. An external permission pin must be low for entry to happen. When an idle request coincides with a valid go write, power-down takes priority.

Once power-down is active, several things happen together:
- The oscillator enable drops.
- The address-latch output, the program-strobe output and the clock-out output are all held low.
- The register contents stay frozen.

Only the synchronous hardware reset leaves power-down. That reset also restores the register default.

Top module: `pwrdn_guard`

## Requirements
- R1: After reset, `osc_en` is 1, `idle_o` is 0, the register reads 0x00, and `ale_i`, `psen_i` and `clkout_i` pass through unchanged to their outputs.
- R2: Power-down is entered under the following sequence:
  - One instruction contains a register write with bit 1 = 1 and bit 6 = 0 (arm).
  - The next instruction contains a register write with bit 6 = 1 and bit 1 = 0 (go).
  - `pd_pin` is low during the go write.
  - Power-down then starts, and `osc_en` reads 0 from the clock edge after the go write onward.
- R3: A write with both bit 1 and bit 6 set neither arms nor starts power-down. A go write without a preceding arm does nothing.
- R4: The armed condition is dropped at any instruction boundary that does not carry a go write. This includes an instruction with no write, and an instruction whose write targets another address.
- R5: Bits 1 and 6 always read 0. The remaining six bits of the register read back the last value written to them, including the values written during an arm or go write.
- R6: While `pd_pin` is high, a go write does not start power-down.
- R7: `idle_o` follows `idle_req` while running. It is 0 in a cycle that carries a valid go write, and it is 0 during power-down.
- R8: During power-down, `osc_en`, `ale_o`, `psen_o` and `clkout_o` are all 0.
- R9: Power-down is held until reset. Register writes during power-down have no effect. Reset restores running operation and the register default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data; holds the register value when `reg_addr` matches, otherwise 0 |
| instr_done | input | 1 | High in the last cycle of each instruction |
| pd_pin | input | 1 | Entry permission; entry is allowed only while this pin is low |
| idle_req | input | 1 | Idle mode request |
| ale_i | input | 1 | Address-latch enable from the core |
| psen_i | input | 1 | Program-strobe from the core |
| clkout_i | input | 1 | Clock-out signal from the core |
| osc_en | output | 1 | Oscillator run enable; 0 during power-down |
| idle_o | output | 1 | Idle grant |
| ale_o | output | 1 | Address-latch pin; forced low during power-down |
| psen_o | output | 1 | Program-strobe pin; forced low during power-down |
| clkout_o | output | 1 | Clock-out pin; stops low during power-down |

## Verification
The bench runs two exhaustive sweeps:
- Sweep one writes all 256 byte values as the instruction after a proper arm. It shows that only values with bit 6 set and bit 1 clear are accepted as the go write.
- Sweep two writes all 256 values as the first instruction, followed by a clean go write. It shows that only values with bit 1 set and bit 6 clear arm the sequence. The same sweep checks the readback mask on every value.

Directed sequences cover the remaining cases. The first group separates a proper pair from pairs that should fail:
- an intervening empty instruction;
- a write to another address;
- a go write sent to the wrong address;
- a repeated arm.

The second group checks the pin veto, idle priority, output forcing, and the freeze and reset release.

// File: rtl/pwrdn_pkg.sv
// Package: shared types for the guarded power-down controller.
// Assumes the register is one byte wide with fixed key-bit positions.
package pwrdn_pkg;

    // Classification of one write cycle to the power-control register.
    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,  // no write, other address, or no key bit set
        WK_ARM   = 2'd1,  // arm bit set, go bit clear
        WK_GO    = 2'd2,  // go bit set, arm bit clear
        WK_BOTH  = 2'd3   // both key bits set: rejected
    } wr_kind_e;

endpackage

// File: rtl/pwrdn_reg.sv
// Module: pwrdn_reg
// Holds the ordinary bits of the power-control register, classifies each
// write by its key bits and returns read data with the key bits at zero.
// Assumes: freeze is high during power-down and blocks every update.
module pwrdn_reg
    import pwrdn_pkg::*;
#(
    parameter int             ADDR_W    = 8,
    parameter int             DATA_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87,
    parameter int             ARM_BIT   = 1,
    parameter int             GO_BIT    = 6,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output wr_kind_e          kind
);

    localparam logic [DATA_W-1:0] KEY_MASK =
        (DATA_W'(1) << ARM_BIT) | (DATA_W'(1) << GO_BIT);

    logic              hit;
    logic [DATA_W-1:0] store_q;

    assign hit = wr && (addr == REG_ADDR);

    // Store the non-key bits; key bits are never kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= RST_VAL & ~KEY_MASK;
        end else if (hit && !freeze) begin
            store_q <= wdata & ~KEY_MASK;
        end
    end

    // Classify the current write by its two key bits.
    always_comb begin
        kind = WK_NONE;
        if (hit) begin
            unique case ({wdata[GO_BIT], wdata[ARM_BIT]})
                2'b01:   kind = WK_ARM;
                2'b10:   kind = WK_GO;
                2'b11:   kind = WK_BOTH;
                default: kind = WK_NONE;
            endcase
        end
    end

    // Read mux: the register value on an address match, zero otherwise.
    assign rdata = (addr == REG_ADDR) ? store_q : '0;

endmodule

// File: rtl/pwrdn_seq.sv
// Module: pwrdn_seq
// Tracks the arm/go key sequence across instruction boundaries and holds
// the sticky power-down state. Also arbitrates idle against power-down.
// Assumes: instr_done marks the last cycle of each instruction, and a write
// in that same cycle belongs to the instruction that is ending.
module pwrdn_seq
    import pwrdn_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wr_kind_e kind,
    input  logic     instr_done,
    input  logic     pd_pin,
    input  logic     idle_req,
    output logic     pd_active,
    output logic     idle_grant
);

    logic arm_now_q;   // an arm write has occurred in the current instruction
    logic armed_q;     // the previous instruction was an arm instruction
    logic go_hit;

    // A valid go write: armed, pin low, still running.
    assign go_hit = (kind == WK_GO) && armed_q && !pd_pin && !pd_active;

    // Move the arm marker across instruction boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_now_q <= 1'b0;
            armed_q   <= 1'b0;
        end else if (!pd_active) begin
            if (instr_done) begin
                armed_q   <= arm_now_q || (kind == WK_ARM);
                arm_now_q <= 1'b0;
            end else if (kind == WK_ARM) begin
                arm_now_q <= 1'b1;
            end
        end
    end

    // Sticky power-down flag; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_active <= 1'b0;
        end else if (go_hit) begin
            pd_active <= 1'b1;
        end
    end

    // Idle grant loses to a concurrent go write and to power-down.
    assign idle_grant = idle_req && !go_hit && !pd_active;

endmodule

// File: rtl/pwrdn_pin_gate.sv
// Module: pwrdn_pin_gate
// Forces a set of output pins low during power-down and drops the oscillator
// enable. Assumes that low is the required parked level for every pin.
module pwrdn_pin_gate #(
    parameter int N_PINS = 3
) (
    input  logic              pd_active,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic              osc_en
);

    // One gate per forced pin.
    for (genvar g = 0; g < N_PINS; g++) begin : g_force
        assign pin_out[g] = pin_in[g] & ~pd_active;
    end

    assign osc_en = ~pd_active;

endmodule

// File: rtl/pwrdn_guard.sv
// Module: pwrdn_guard (top)
// Guarded power-down entry controller. It ties the register, the key
// sequencer and the pin gate together.
// Assumes: clk keeps running as a reference so that the block can see the
// reset. All state of the rest of the chip freezes once osc_en drops.
module pwrdn_guard
    import pwrdn_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87,
    parameter int                ARM_BIT  = 1,
    parameter int                GO_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              instr_done,
    input  logic              pd_pin,
    input  logic              idle_req,
    input  logic              ale_i,
    input  logic              psen_i,
    input  logic              clkout_i,
    output logic              osc_en,
    output logic              idle_o,
    output logic              ale_o,
    output logic              psen_o,
    output logic              clkout_o
);

    localparam int N_FORCED = 3;

    wr_kind_e            kind;
    logic                pd_active;
    logic [N_FORCED-1:0] forced_in;
    logic [N_FORCED-1:0] forced_out;

    pwrdn_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .REG_ADDR (REG_ADDR),
        .ARM_BIT  (ARM_BIT),
        .GO_BIT   (GO_BIT),
        .RST_VAL  ('0)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (pd_active),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .kind   (kind)
    );

    pwrdn_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .instr_done (instr_done),
        .pd_pin     (pd_pin),
        .idle_req   (idle_req),
        .pd_active  (pd_active),
        .idle_grant (idle_o)
    );

    assign forced_in = {clkout_i, psen_i, ale_i};

    pwrdn_pin_gate #(.N_PINS(N_FORCED)) u_gate (
        .pd_active (pd_active),
        .pin_in    (forced_in),
        .pin_out   (forced_out),
        .osc_en    (osc_en)
    );

    assign ale_o    = forced_out[0];
    assign psen_o   = forced_out[1];
    assign clkout_o = forced_out[2];

endmodule

// File: rtl/pwrdn_guard_chk.sv
// Module: pwrdn_guard_chk
// Property checker for pwrdn_guard. It sees only the top-level ports and is
// attached with bind.
module pwrdn_guard_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87,
    parameter int                ARM_BIT  = 1,
    parameter int                GO_BIT   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              pd_pin,
    input logic              osc_en,
    input logic              idle_o,
    input logic              ale_o,
    input logic              psen_o,
    input logic              clkout_o
);

    // R8
    pd_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!ale_o && !psen_o && !clkout_o));

    // R9
    pd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !osc_en);

    // R5
    key_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[ARM_BIT] && !reg_rdata[GO_BIT]);

    // R3
    both_keys_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && reg_wr && reg_addr == REG_ADDR &&
         reg_wdata[ARM_BIT] && reg_wdata[GO_BIT]) |=> osc_en);

    // R6
    pin_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && pd_pin) |=> osc_en);

    // R2
    entry_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !(reg_wr && reg_addr == REG_ADDR &&
                     reg_wdata[GO_BIT] && !reg_wdata[ARM_BIT])) |=> osc_en);

    // R7
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && osc_en) |=> (osc_en || !$past(idle_o)) && !(idle_o && !osc_en));

endmodule

bind pwrdn_guard pwrdn_guard_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR),
    .ARM_BIT  (ARM_BIT),
    .GO_BIT   (GO_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pd_pin    (pd_pin),
    .osc_en    (osc_en),
    .idle_o    (idle_o),
    .ale_o     (ale_o),
    .psen_o    (psen_o),
    .clkout_o  (clkout_o)
);

// File: tb/pwrdn_guard_bench.sv
// Bench for pwrdn_guard: exhaustive key sweeps plus directed sequences.
`timescale 1ns/1ps
module pwrdn_guard_bench;

    localparam logic [7:0] RA = 8'h87;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = RA;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       instr_done = 1'b0;
    logic       pd_pin = 1'b0;
    logic       idle_req = 1'b0;
    logic       ale_i = 1'b1, psen_i = 1'b1, clkout_i = 1'b1;
    logic       osc_en, idle_o, ale_o, psen_o, clkout_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    logic idle_seen;

    always #4 clk = ~clk;

    pwrdn_guard u_pwrdn_guard (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .instr_done(instr_done),
        .pd_pin(pd_pin), .idle_req(idle_req), .ale_i(ale_i), .psen_i(psen_i),
        .clkout_i(clkout_i), .osc_en(osc_en), .idle_o(idle_o), .ale_o(ale_o),
        .psen_o(psen_o), .clkout_o(clkout_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One instruction lasting one cycle; optional write; idle seen mid-cycle.
    task automatic instr(input bit wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; instr_done = 1'b1;
        #1 idle_seen = idle_o;
        @(negedge clk);
        reg_wr = 1'b0; instr_done = 1'b0; reg_addr = RA;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=0x1 expected=0x0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check(osc_en === 1'b1, "R1 osc_en", int'(osc_en), 1);
        check(reg_rdata === 8'h00, "R1 rdata", int'(reg_rdata), 0);
        check({ale_o, psen_o, clkout_o} === 3'b111, "R1 passthrough",
              int'({ale_o, psen_o, clkout_o}), 7);
        check(idle_o === 1'b0, "R1 idle", int'(idle_o), 0);

        // R2/R3 sweep of the second write after a proper arm
        for (int v = 0; v < 256; v++) begin
            do_reset();
            instr(1'b1, RA, 8'h02);
            instr(1'b1, RA, 8'(v));
            check(osc_en === !(v[6] && !v[1]), "R2 R3 go sweep", int'(osc_en),
                  int'(!(v[6] && !v[1])));
        end

        // R2/R3/R5 sweep of the first write followed by a clean go
        for (int v = 0; v < 256; v++) begin
            do_reset();
            instr(1'b1, RA, 8'(v));
            check(reg_rdata === (8'(v) & 8'hBD), "R5 readback mask",
                  int'(reg_rdata), v & 8'hBD);
            instr(1'b1, RA, 8'h40);
            check(osc_en === !(v[1] && !v[6]), "R2 R3 arm sweep", int'(osc_en),
                  int'(!(v[1] && !v[6])));
        end

        // R3 go without arm
        do_reset();
        instr(1'b1, RA, 8'h40);
        check(osc_en === 1'b1, "R3 go unarmed", int'(osc_en), 1);

        // R4 empty instruction between arm and go
        do_reset();
        instr(1'b1, RA, 8'h02); instr(1'b0, RA, 8'h00); instr(1'b1, RA, 8'h40);
        check(osc_en === 1'b1, "R4 gap instr", int'(osc_en), 1);
        // R4 other-address write between arm and go
        do_reset();
        instr(1'b1, RA, 8'h02); instr(1'b1, 8'h80, 8'h40); instr(1'b1, RA, 8'h40);
        check(osc_en === 1'b1, "R4 other addr", int'(osc_en), 1);
        // R4 go to wrong address
        do_reset();
        instr(1'b1, RA, 8'h02); instr(1'b1, 8'h80, 8'h40);
        check(osc_en === 1'b1, "R4 go wrong addr", int'(osc_en), 1);
        // R2 repeated arm then go
        do_reset();
        instr(1'b1, RA, 8'h02); instr(1'b1, RA, 8'h02); instr(1'b1, RA, 8'h40);
        check(osc_en === 1'b0, "R2 rearm", int'(osc_en), 0);

        // R6 pin veto
        do_reset();
        pd_pin = 1'b1;
        instr(1'b1, RA, 8'h02); instr(1'b1, RA, 8'h40);
        check(osc_en === 1'b1, "R6 pin high", int'(osc_en), 1);
        pd_pin = 1'b0;

        // R7 idle arbitration
        do_reset();
        idle_req = 1'b1;
        instr(1'b0, RA, 8'h00);
        check(idle_seen === 1'b1, "R7 idle pass", int'(idle_seen), 1);
        instr(1'b1, RA, 8'h02);
        instr(1'b1, RA, 8'h40);
        check(idle_seen === 1'b0, "R7 idle vs go", int'(idle_seen), 0);
        check(osc_en === 1'b0, "R7 pd wins", int'(osc_en), 0);
        check(idle_o === 1'b0, "R7 idle in pd", int'(idle_o), 0);
        idle_req = 1'b0;

        // R8 forced pins, R9 freeze and reset release
        do_reset();
        instr(1'b1, RA, 8'hA5);
        instr(1'b1, RA, 8'h02);
        instr(1'b1, RA, 8'h40);
        check(osc_en === 1'b0, "R8 osc stop", int'(osc_en), 0);
        check({ale_o, psen_o, clkout_o} === 3'b000, "R8 pins low",
              int'({ale_o, psen_o, clkout_o}), 0);
        check(reg_rdata === 8'h00, "R9 go write other bits", int'(reg_rdata), 0);
        instr(1'b1, RA, 8'hFF);
        check(reg_rdata === 8'h00, "R9 frozen", int'(reg_rdata), 0);
        repeat (5) instr(1'b0, RA, 8'h00);
        check(osc_en === 1'b0, "R9 sticky", int'(osc_en), 0);
        do_reset();
        check(osc_en === 1'b1, "R9 reset exit", int'(osc_en), 1);
        check(ale_o === 1'b1, "R9 pins released", int'(ale_o), 1);
        check(reg_rdata === 8'h00, "R9 default", int'(reg_rdata), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule